// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller with Way Locking

This block holds the tags, valid bits, dirty bits, replacement state and a small data array for a two-way set-associative data cache. The set is selected by index bits taken from the virtual address. The physical tag arrives in the same cycle from a translation step that runs in parallel, and it is compared against both ways. Each request carries a page attribute that selects the write policy for that access: write-back or write-through.

Software-controlled lock inputs, one per way, keep the lines of a way from being replaced. Hits on a locked way still work as usual. On a miss the controller chooses a victim. If that victim is dirty, the controller first raises a write-back request for it, and then it asks for a refill. The refill returns the line one doubleword at a time, starting with the doubleword that was requested and wrapping around the line. The stalled access gets its response on the first returned beat, while the rest of the line is still arriving. The default parameters give 16 sets of four doublewords per way. Setting the index width to 9 gives two 16KB ways, which is 32KB in total.

Top module: `cache2w_ctl`

## Requirements
- R1: An accepted read that hits returns the stored doubleword with `resp_valid` in the cycle after acceptance, and no refill is requested.
- R2: The set is chosen by `req_vidx`. A hit requires a valid line in that set whose stored tag equals `req_ptag`. A line with a different tag in the same set is a miss.
- R3: A miss that allocates, or a read miss, raises `fill_req` with `fill_tag`/`fill_idx` equal to the request and `fill_off` equal to the requested doubleword. Beat k is written to offset `fill_off + k`, modulo the number of doublewords per line.
- R4: On a refill, `resp_valid` is asserted in the cycle after the first beat is accepted, before any later beat.
- R5: The victim is the way least recently used in that set, among the unlocked ways. Both hits and completed refills update the recency. After reset, way 0 is evicted first.
- R6: While `lock[w]` is 1, way w is never replaced. When both ways are locked, a read miss is fetched and answered but not stored, and a write-back-page store miss is posted on the write-through port.
- R7: A store hit on a write-back page (`req_wt`=0) updates the line, marks it dirty and posts nothing.
- R8: A store on a write-through page (`req_wt`=1) posts `wt_valid` with its address and data in the cycle after acceptance. On a hit it also updates the line. On a miss it allocates nothing.
- R9: A write-back-page store miss allocates the line: it is refilled, the store data replaces the requested doubleword, and the line becomes dirty.
- R10: A dirty victim raises `wb_valid` with its tag and set, held stable until `wb_ready`. `fill_req` stays low until the write-back has been accepted.
- R11: After reset all lines are invalid and `busy`, `resp_valid`, `fill_req`, `wb_valid` and `wt_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, accepted when `busy` is 0 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | Page attribute: 1 = write-through, 0 = write-back |
| req_vidx | input | IDX_W | Set index from the virtual address |
| req_off | input | OFF_W | Doubleword within the line |
| req_ptag | input | TAG_W | Physical tag from translation |
| req_wdata | input | DATA_W | Store data |
| lock | input | 2 | Per-way replacement lock |
| busy | output | 1 | Controller is servicing a miss |
| resp_valid | output | 1 | Access completed (one-cycle pulse) |
| resp_rdata | output | DATA_W | Load data |
| wb_valid | output | 1 | Dirty-victim write-back request |
| wb_tag | output | TAG_W | Victim tag |
| wb_idx | output | IDX_W | Victim set |
| wb_ready | input | 1 | Write-back accepted |
| fill_req | output | 1 | Refill in progress |
| fill_tag | output | TAG_W | Refill tag |
| fill_idx | output | IDX_W | Refill set |
| fill_off | output | OFF_W | Critical doubleword offset |
| fill_valid | input | 1 | Refill beat valid |
| fill_data | input | DATA_W | Refill beat data |
| wt_valid | output | 1 | Posted store (one-cycle pulse) |
| wt_tag | output | TAG_W | Posted store tag |
| wt_idx | output | IDX_W | Posted store set |
| wt_off | output | OFF_W | Posted store doubleword |
| wt_data | output | DATA_W | Posted store data |

## Verification
Some rules are checked by assertions on every cycle. A write-back request never overlaps a refill, and its address stays stable until it is accepted. The idle controller drives no refill or write-back request. A posted store always follows an accepted store, and an allocating miss leads to a write-back or refill in the next cycle. Other behaviour can only be shown by the bench scenarios, which track line contents across many accesses: recency-based victim choice, a lock that preserves its way's lines, no allocation when both ways are locked or on write-through misses, merging of a store into a refilled line, the wrapping beat order, and a response that comes back after exactly one refill beat.

// File: rtl/cache2w_ctl.sv
module cache2w_ctl #(
  parameter int TAG_W  = 8,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wt,
  input  logic [IDX_W-1:0]  req_vidx,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [TAG_W-1:0]  req_ptag,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        lock,
  output logic              busy,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [IDX_W-1:0]  wb_idx,
  input  logic              wb_ready,
  output logic              fill_req,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [OFF_W-1:0]  fill_off,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              wt_valid,
  output logic [TAG_W-1:0]  wt_tag,
  output logic [IDX_W-1:0]  wt_idx,
  output logic [OFF_W-1:0]  wt_off,
  output logic [DATA_W-1:0] wt_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL} st_t;
  st_t st;

  logic [TAG_W-1:0]  tag_q [2][SETS];
  logic              val_q [2][SETS];
  logic              dty_q [2][SETS];
  logic              lru_q [SETS];
  logic [DATA_W-1:0] mem_q [2][SETS*WORDS];

  logic [TAG_W-1:0]  m_tag;
  logic [IDX_W-1:0]  m_idx;
  logic [OFF_W-1:0]  m_off;
  logic [OFF_W-1:0]  beat;
  logic [DATA_W-1:0] m_wdata;
  logic              m_way, m_wr, m_alloc;

  logic hit0, hit1, hit, hway, accept, both_lk, vway, no_alloc_st, fetch_go;
  logic first_beat, last_beat;
  logic [OFF_W-1:0] fill_word;

  assign hit0        = val_q[0][req_vidx] && (tag_q[0][req_vidx] == req_ptag);
  assign hit1        = val_q[1][req_vidx] && (tag_q[1][req_vidx] == req_ptag);
  assign hit         = hit0 || hit1;
  assign hway        = hit1;
  assign accept      = req_valid && (st == S_IDLE);
  assign both_lk     = &lock;
  assign vway        = lock[0] ? 1'b1 : (lock[1] ? 1'b0 : lru_q[req_vidx]);
  assign no_alloc_st = req_write && (req_wt || both_lk);
  assign fetch_go    = accept && !hit && !no_alloc_st;
  assign first_beat  = (beat == '0);
  assign last_beat   = &beat;
  assign fill_word   = m_off + beat;

  assign busy     = (st != S_IDLE);
  assign wb_valid = (st == S_EVICT);
  assign fill_req = (st == S_FILL);
  assign fill_tag = m_tag;
  assign fill_idx = m_idx;
  assign fill_off = m_off;

  logic              dwe, dway;
  logic [IDX_W+OFF_W-1:0] daddr;
  logic [DATA_W-1:0] dwdata;
  logic              fill_beat;

  assign fill_beat = (st == S_FILL) && fill_valid;

  always_comb begin
    dwe    = 1'b0;
    dway   = hway;
    daddr  = {req_vidx, req_off};
    dwdata = req_wdata;
    if (accept && hit && req_write) begin
      dwe = 1'b1;
    end else if (fill_beat && m_alloc) begin
      dwe    = 1'b1;
      dway   = m_way;
      daddr  = {m_idx, fill_word};
      dwdata = (first_beat && m_wr) ? m_wdata : fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (dwe) mem_q[dway][daddr] <= dwdata;
    if (fill_beat && last_beat && m_alloc) tag_q[m_way][m_idx] <= m_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      wt_valid   <= 1'b0;
      wt_tag     <= '0;
      wt_idx     <= '0;
      wt_off     <= '0;
      wt_data    <= '0;
      wb_tag     <= '0;
      wb_idx     <= '0;
      m_tag      <= '0;
      m_idx      <= '0;
      m_off      <= '0;
      m_wdata    <= '0;
      m_way      <= 1'b0;
      m_wr       <= 1'b0;
      m_alloc    <= 1'b0;
      beat       <= '0;
      for (int s = 0; s < SETS; s++) begin
        val_q[0][s] <= 1'b0;
        val_q[1][s] <= 1'b0;
        dty_q[0][s] <= 1'b0;
        dty_q[1][s] <= 1'b0;
        lru_q[s]    <= 1'b0;
      end
    end else begin
      resp_valid <= 1'b0;
      wt_valid   <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (hit) begin
            lru_q[req_vidx] <= ~hway;
            resp_valid      <= 1'b1;
            resp_rdata      <= mem_q[hway][{req_vidx, req_off}];
            if (req_write && !req_wt) dty_q[hway][req_vidx] <= 1'b1;
          end else if (no_alloc_st) begin
            resp_valid <= 1'b1;
          end else begin
            m_tag   <= req_ptag;
            m_idx   <= req_vidx;
            m_off   <= req_off;
            m_wdata <= req_wdata;
            m_wr    <= req_write;
            m_way   <= vway;
            m_alloc <= !both_lk;
            beat    <= '0;
            if (!both_lk) begin
              val_q[vway][req_vidx] <= 1'b0;
              dty_q[vway][req_vidx] <= 1'b0;
            end
            if (!both_lk && val_q[vway][req_vidx] && dty_q[vway][req_vidx]) begin
              st     <= S_EVICT;
              wb_tag <= tag_q[vway][req_vidx];
              wb_idx <= req_vidx;
            end else begin
              st <= S_FILL;
            end
          end
          if (req_write && (req_wt || (!hit && both_lk))) begin
            wt_valid <= 1'b1;
            wt_tag   <= req_ptag;
            wt_idx   <= req_vidx;
            wt_off   <= req_off;
            wt_data  <= req_wdata;
          end
        end
        S_EVICT: if (wb_ready) st <= S_FILL;
        S_FILL: if (fill_valid) begin
          beat <= beat + 1'b1;
          if (first_beat) begin
            resp_valid <= 1'b1;
            resp_rdata <= m_wr ? m_wdata : fill_data;
          end
          if (last_beat) begin
            st <= S_IDLE;
            if (m_alloc) begin
              val_q[m_way][m_idx] <= 1'b1;
              dty_q[m_way][m_idx] <= m_wr;
              lru_q[m_idx]        <= ~m_way;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             busy,
  input logic             fill_req,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [TAG_W-1:0] wb_tag,
  input logic [IDX_W-1:0] wb_idx,
  input logic             wt_valid,
  input logic             fetch_go
);
  assert_wb_before_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !fill_req);

  assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_tag) && $stable(wb_idx));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fill_req && !wb_valid);

  assert_post_follows_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid |-> $past(req_valid && req_write && !busy));

  assert_miss_starts_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> fill_req || wb_valid);
endmodule

bind cache2w_ctl cache2w_chk #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .busy(busy), .fill_req(fill_req), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_tag(wb_tag), .wb_idx(wb_idx), .wt_valid(wt_valid), .fetch_go(fetch_go)
);

// File: tb/cache2w_ctl_bench.sv
module cache2w_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wt = 1'b0;
  logic [3:0] req_vidx = '0;
  logic [1:0] req_off = '0;
  logic [7:0] req_ptag = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0] lock = 2'b00;
  logic busy, resp_valid, wb_valid, fill_req, wt_valid;
  logic [63:0] resp_rdata, wt_data;
  logic [7:0] wb_tag, fill_tag, wt_tag;
  logic [3:0] wb_idx, fill_idx, wt_idx;
  logic [1:0] fill_off, wt_off;
  logic wb_ready = 1'b0, fill_valid = 1'b0;
  logic [63:0] fill_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache2w_ctl u_cache2w_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_wt(req_wt),
    .req_vidx(req_vidx), .req_off(req_off), .req_ptag(req_ptag), .req_wdata(req_wdata),
    .lock(lock), .busy(busy), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_idx(wb_idx), .wb_ready(wb_ready),
    .fill_req(fill_req), .fill_tag(fill_tag), .fill_idx(fill_idx), .fill_off(fill_off),
    .fill_valid(fill_valid), .fill_data(fill_data), .wt_valid(wt_valid), .wt_tag(wt_tag),
    .wt_idx(wt_idx), .wt_off(wt_off), .wt_data(wt_data));

  function automatic logic [63:0] pat(input logic [7:0] t, input logic [3:0] i, input logic [1:0] o);
    return {24'hC0FFEE, t, 4'h0, i, 6'h0, o, 16'h5A5A};
  endfunction

  localparam logic [63:0] D1 = 64'h1111_2222_3333_4444;
  localparam logic [63:0] D2 = 64'hDEAD_0000_BEEF_0002;
  localparam logic [63:0] D3 = 64'hDEAD_0000_BEEF_0003;
  localparam logic [63:0] D4 = 64'h0123_4567_89AB_CDEF;

  localparam logic       T_WR  [N] = '{0,0,0,0,1,0,0,0,0,1,0,1,0,1,0,0,0,0};
  localparam logic       T_WT  [N] = '{0,0,0,0,0,0,0,0,0,1,0,1,0,0,0,0,0,0};
  localparam logic [3:0] T_IDX [N] = '{3,3,3,3,3,3,3,3,3,5,5,5,5,6,6,6,6,6};
  localparam logic [1:0] T_OFF [N] = '{1,2,0,1,1,1,3,0,1,0,0,0,0,2,2,3,2,0};
  localparam logic [7:0] T_TAG [N] = '{8'h11,8'h11,8'h22,8'h11,8'h11,8'h11,8'h33,8'h44,8'h11,
                                       8'h55,8'h55,8'h55,8'h55,8'h66,8'h66,8'h66,8'h77,8'h88};
  localparam logic [63:0] T_WD [N] = '{0,0,0,0,D1,0,0,0,0,D2,0,D3,0,D4,0,0,0,0};
  localparam logic [63:0] T_EXP [N] = '{pat(8'h11,3,1), pat(8'h11,3,2), pat(8'h22,3,0), pat(8'h11,3,1),
                                        0, D1, pat(8'h33,3,3), pat(8'h44,3,0), pat(8'h11,3,1),
                                        0, pat(8'h55,5,0), 0, D3, 0, D4, pat(8'h66,6,3),
                                        pat(8'h77,6,2), pat(8'h88,6,0)};
  localparam logic       T_FILL [N] = '{1,0,1,0,0,0,1,1,1,0,1,0,0,1,0,0,1,1};
  localparam logic       T_WB   [N] = '{0,0,0,0,0,0,0,1,0,0,0,0,0,0,0,0,0,1};
  localparam string      T_REQ  [N] = '{"R3","R3","R5","R2","R7","R7","R5","R10","R5",
                                        "R8","R8","R8","R8","R9","R9","R9","R5","R10"};

  int total = 0, bad = 0;
  int fill_cnt = 0, wb_cnt = 0, wt_cnt = 0, beats = 0;
  logic [7:0] f_tag, last_wb_tag;
  logic [3:0] f_idx, last_wb_idx;
  logic [1:0] f_off;
  logic [63:0] last_wt_data;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (fill_req) begin
        f_tag = fill_tag; f_idx = fill_idx; f_off = fill_off;
        fill_cnt++; beats = 0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          fill_valid = 1'b1;
          fill_data  = pat(f_tag, f_idx, f_off + 2'(k));
          beats      = k + 1;
          @(negedge clk);
          fill_valid = 1'b0;
          @(negedge clk);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (wb_valid) begin
        wb_cnt++; last_wb_tag = wb_tag; last_wb_idx = wb_idx;
        repeat (2) @(negedge clk);
        wb_ready = 1'b1;
        @(negedge clk);
        wb_ready = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (wt_valid) begin
        wt_cnt++; last_wt_data = wt_data;
      end
    end
  end

  task automatic access(input logic wr, input logic wt, input logic [3:0] idx, input logic [1:0] off,
                        input logic [7:0] tg, input logic [63:0] wd, input logic [63:0] exp_d,
                        input logic e_fill, input logic e_wb, input string rq);
    int f0, b0, w0, bt;
    logic [63:0] got;
    f0 = fill_cnt; b0 = wb_cnt; w0 = wt_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wt = wt; req_vidx = idx;
    req_off = off; req_ptag = tg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    got = resp_rdata; bt = beats;
    while (busy) @(negedge clk);
    @(negedge clk);
    if (!wr) chk({rq, " load data"}, got, exp_d);
    chk({rq, " refill count"}, 64'(fill_cnt - f0), 64'(e_fill));
    chk({rq, " writeback count"}, 64'(wb_cnt - b0), 64'(e_wb));
    chk({"R8 ", rq, " posted store count"}, 64'(wt_cnt - w0), 64'(wr && (wt || (lock == 2'b11 && !e_fill))));
    if (e_fill) begin
      chk("R4 beats before restart", 64'(bt), 64'd1);
      chk("R3 refill address", {f_tag, f_idx, f_off}, {tg, idx, off});
    end
    if (wr && wt) chk("R8 posted data", last_wt_data, wd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy after reset", 64'(busy), 0);
    chk("R11 outputs idle after reset", {resp_valid, fill_req, wb_valid, wt_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++)
      access(T_WR[i], T_WT[i], T_IDX[i], T_OFF[i], T_TAG[i], T_WD[i], T_EXP[i], T_FILL[i], T_WB[i], T_REQ[i]);
    chk("R10 victim address", {last_wb_tag, last_wb_idx}, {8'h66, 4'd6});
    // R1 hit of a line left in way 0 at set 3
    access(0, 0, 3, 2, 8'h44, 0, pat(8'h44, 3, 2), 0, 0, "R1");
    // R6 locking, set 9
    access(0, 0, 9, 0, 8'hA1, 0, pat(8'hA1, 9, 0), 1, 0, "R6");
    access(0, 0, 9, 0, 8'hB2, 0, pat(8'hB2, 9, 0), 1, 0, "R6");
    lock = 2'b01;
    access(0, 0, 9, 0, 8'hC3, 0, pat(8'hC3, 9, 0), 1, 0, "R6");
    access(0, 0, 9, 0, 8'hA1, 0, pat(8'hA1, 9, 0), 0, 0, "R6 locked way kept");
    access(0, 0, 9, 1, 8'hB2, 0, pat(8'hB2, 9, 1), 1, 0, "R6");
    lock = 2'b11;
    access(0, 0, 9, 2, 8'hD4, 0, pat(8'hD4, 9, 2), 1, 0, "R6 no alloc");
    access(0, 0, 9, 2, 8'hD4, 0, pat(8'hD4, 9, 2), 1, 0, "R6 no alloc again");
    access(0, 0, 9, 3, 8'hA1, 0, pat(8'hA1, 9, 3), 0, 0, "R6 way0 intact");
    access(0, 0, 9, 3, 8'hB2, 0, pat(8'hB2, 9, 3), 0, 0, "R6 way1 intact");
    access(1, 0, 9, 0, 8'hE5, D2, 0, 0, 0, "R6 locked store");
    chk("R6 locked store posted", last_wt_data, D2);
    lock = 2'b00;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule